// File: doc/BRIEF.md
# Sliced-Channel Wormhole Path Controller

This block governs one input-to-output connection of a wormhole router. The channel is divided into narrow, independent sub-channels, called lanes here. The default is 16 lanes of 2 bits each, for a 32-bit channel. Every lane carries its own full copy of a frame: a head, some data items and a tail marked by an end-of-frame (eof) flag. Each lane uses its own valid/ready handshake, so one lane may run several items ahead of a stalled neighbour. No global completion detector forces the lanes into step.

An external arbiter issues a grant. The block then holds the path and waits for the routing stage to report either a decision or an error. Until that report arrives, no lane moves.

- After a good decision, items pass straight through each lane.
- After an error, every lane acknowledges its input through eof and forwards nothing, so upstream drains the faulty frame.

Each lane raises a finish flag once its eof has been accepted, and from then on it refuses further items. When all finish flags are set, the block pulses a release. In the following cycle the hold is dropped and the flags are cleared, so the next head can be routed.

Top module: `sliced_path_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, `hold_o`, `release_o`, `err_o`, every `in_ready_o`, every `out_valid_o` and every `lane_fin_o` bit are 0.
- R2: `grant_i` seen while idle sets `hold_o` from the next cycle on. Until a routing report (`route_vld_i`=1) is taken, every `in_ready_o` and `out_valid_o` bit stays 0.
- R3: Once a routing report with `route_err_i`=0 has been taken, each unfinished lane presents `out_valid_o`=`in_valid_i`, with matching data and eof.
- R4: In forwarding, each unfinished lane has `in_ready_o` equal to its own `out_ready_i`, whatever the other lanes do.
- R5: After a lane accepts an item with eof=1, its `lane_fin_o` bit is 1, and its `in_ready_o` and `out_valid_o` are 0 until release.
- R6: `release_o` is 1 exactly in the cycles where the path is active and all lane finish flags are set. In the next cycle `hold_o` is 0 and all `lane_fin_o` bits are 0.
- R7: A routing report with `route_err_i`=1 enters drop mode. In drop mode `err_o` is 1, no lane asserts `out_valid_o`, and each unfinished lane has `in_ready_o`=1 regardless of `out_ready_i`.
- R8: A routing report or grant that arrives while the path is already forwarding has no effect: `err_o` stays 0 and forwarding continues.
- R9: Within each lane, the output items appear in input order. No lane delivers an item after its eof within the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grant_i | input | 1 | Crossbar grant from the arbiter |
| route_vld_i | input | 1 | Routing report strobe |
| route_err_i | input | 1 | Report qualifier: 1 = faulty frame |
| hold_o | output | 1 | Path held (grant kept) |
| release_o | output | 1 | All lanes finished; path released this cycle |
| err_o | output | 1 | Current frame is being dropped |
| in_valid_i | input | LANES | Per-lane input valid |
| in_data_i | input | LANES*LANE_W | Lane data, lane l at bits [l*LANE_W +: LANE_W] |
| in_eof_i | input | LANES | Per-lane end-of-frame marker |
| in_ready_o | output | LANES | Per-lane input ready |
| out_valid_o | output | LANES | Per-lane output valid |
| out_data_o | output | LANES*LANE_W | Lane output data |
| out_eof_o | output | LANES | Per-lane output end-of-frame |
| out_ready_i | input | LANES | Per-lane output ready |
| lane_fin_o | output | LANES | Per-lane finish flag |

## Verification
The properties assume three things about the inputs:
- the arbiter grants only an idle path;
- each lane's frame carries exactly one eof;
- a routing report is given once per frame.

The bench stays within these rules. It raises the grant only after the previous release, it ends each lane's item sequence with a single eof, and it presents valid on finished lanes only with items that must be refused. The one exception is a stray routing report sent on purpose while a frame is forwarding. That report lands in a state where the block must ignore it, so no property depends on it.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROUTE = 2'd1,
    ST_FWD   = 2'd2,
    ST_DROP  = 2'd3
  } path_st_e;
endpackage

// File: rtl/slice_lane.sv
module slice_lane #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         drop_i,
  input  logic         clr_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  input  logic         in_eof_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  output logic         out_eof_o,
  input  logic         out_ready_i,
  output logic         fin_o
);
  logic fin_q;
  logic live;

  assign live        = en_i & ~fin_q;
  assign out_valid_o = live & ~drop_i & in_valid_i;
  // dropped items are swallowed whatever downstream does
  assign in_ready_o  = live & (drop_i | out_ready_i);
  assign out_data_o  = in_data_i;
  assign out_eof_o   = in_eof_i;
  assign fin_o       = fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   fin_q <= 1'b0;
    else if (clr_i)                                fin_q <= 1'b0;
    else if (in_valid_i && in_ready_o && in_eof_i) fin_q <= 1'b1;
  end

  AST_FIN_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> (!in_ready_o && !out_valid_o)); // R5
  AST_EOF_SETS_FIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_eof_i && !clr_i) |=> fin_o); // R5
  AST_DROP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |-> !out_valid_o); // R7
  AST_IDLE_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!in_ready_o && !out_valid_o)); // R2
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import slice_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic route_vld_i,
  input  logic route_err_i,
  input  logic all_fin_i,
  output logic en_o,
  output logic drop_o,
  output logic release_o,
  output logic hold_o,
  output logic err_o
);
  path_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (grant_i)     st_d = ST_ROUTE;
      ST_ROUTE: if (route_vld_i) st_d = route_err_i ? ST_DROP : ST_FWD;
      ST_FWD,
      ST_DROP:  if (all_fin_i)   st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign en_o      = (st_q == ST_FWD) || (st_q == ST_DROP);
  assign drop_o    = (st_q == ST_DROP);
  assign err_o     = drop_o;
  assign hold_o    = (st_q != ST_IDLE);
  assign release_o = en_o & all_fin_i;

  AST_HOLD_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && grant_i) |=> (hold_o && !en_o)); // R2
  AST_ERR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !release_o) |=> err_o); // R7
  AST_FWD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && !err_o && !release_o) |=> (en_o && !err_o)); // R8
endmodule

// File: rtl/sliced_path_ctrl.sv
module sliced_path_ctrl #(
  parameter int LANES  = 16,
  parameter int LANE_W = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      grant_i,
  input  logic                      route_vld_i,
  input  logic                      route_err_i,
  output logic                      hold_o,
  output logic                      release_o,
  output logic                      err_o,
  input  logic [LANES-1:0]          in_valid_i,
  input  logic [LANES*LANE_W-1:0]   in_data_i,
  input  logic [LANES-1:0]          in_eof_i,
  output logic [LANES-1:0]          in_ready_o,
  output logic [LANES-1:0]          out_valid_o,
  output logic [LANES*LANE_W-1:0]   out_data_o,
  output logic [LANES-1:0]          out_eof_o,
  input  logic [LANES-1:0]          out_ready_i,
  output logic [LANES-1:0]          lane_fin_o
);
  logic en, drop, all_fin;

  assign all_fin = &lane_fin_o;

  frame_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant_i),
    .route_vld_i (route_vld_i),
    .route_err_i (route_err_i),
    .all_fin_i   (all_fin),
    .en_o        (en),
    .drop_o      (drop),
    .release_o   (release_o),
    .hold_o      (hold_o),
    .err_o       (err_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    slice_lane #(.W(LANE_W)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en),
      .drop_i      (drop),
      .clr_i       (release_o),
      .in_valid_i  (in_valid_i[l]),
      .in_data_i   (in_data_i[l*LANE_W +: LANE_W]),
      .in_eof_i    (in_eof_i[l]),
      .in_ready_o  (in_ready_o[l]),
      .out_valid_o (out_valid_o[l]),
      .out_data_o  (out_data_o[l*LANE_W +: LANE_W]),
      .out_eof_o   (out_eof_o[l]),
      .out_ready_i (out_ready_i[l]),
      .fin_o       (lane_fin_o[l])
    );
  end

  AST_RELEASE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> (lane_fin_o == '0 && !hold_o)); // R6
  AST_RELEASE_NEEDS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> (hold_o && lane_fin_o == '1)); // R6
  AST_NOTHING_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o |-> (in_ready_o == '0 && out_valid_o == '0 && lane_fin_o == '0)); // R1
endmodule

// File: tb/sliced_path_ctrl_bench.sv
module sliced_path_ctrl_bench;
  localparam int LANES  = 16;
  localparam int LANE_W = 2;
  localparam int NF     = 6;
  // {drop(1), stall percent(7), base length(8)}
  localparam logic [15:0] FRAMES [NF] = '{
    {1'b0, 7'd0,  8'd3},
    {1'b0, 7'd40, 8'd4},
    {1'b1, 7'd30, 8'd3},
    {1'b0, 7'd70, 8'd2},
    {1'b1, 7'd0,  8'd1},
    {1'b0, 7'd55, 8'd6}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic grant_i = 0, route_vld_i = 0, route_err_i = 0;
  logic hold_o, release_o, err_o;
  logic [LANES-1:0] in_valid_i = '0, in_eof_i = '0, out_ready_i = '0;
  logic [LANES*LANE_W-1:0] in_data_i = '0;
  logic [LANES-1:0] in_ready_o, out_valid_o, out_eof_o, lane_fin_o;
  logic [LANES*LANE_W-1:0] out_data_o;

  int errors = 0, checks = 0;
  int in_cnt [LANES];
  int out_cnt[LANES];
  int len    [LANES];
  bit hs_in  [LANES];
  bit hs_out [LANES];

  always #5 clk = ~clk;

  sliced_path_ctrl #(.LANES(LANES), .LANE_W(LANE_W)) u_sliced_path_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .grant_i(grant_i), .route_vld_i(route_vld_i),
    .route_err_i(route_err_i), .hold_o(hold_o), .release_o(release_o), .err_o(err_o),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_eof_i(in_eof_i),
    .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_eof_o(out_eof_o), .out_ready_i(out_ready_i), .lane_fin_o(lane_fin_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [LANE_W-1:0] item(input int f, input int l, input int k);
    return LANE_W'(f * 3 + l + k * (l % 3 + 1));
  endfunction

  task automatic run_frame(input int f);
    bit drop = FRAMES[f][15];
    int pct  = int'(FRAMES[f][14:8]);
    int base = int'(FRAMES[f][7:0]);
    int cyc  = 0;
    bit done = 0;
    for (int l = 0; l < LANES; l++) begin
      len[l] = base + (l % 3); in_cnt[l] = 0; out_cnt[l] = 0;
      hs_in[l] = 0; hs_out[l] = 0;
    end
    @(negedge clk);
    grant_i = 1;
    for (int l = 0; l < LANES; l++) begin
      in_valid_i[l] = 1'b1;
      in_data_i[l*LANE_W +: LANE_W] = item(f, l, 0);
      in_eof_i[l] = (len[l] == 1);
    end
    out_ready_i = '1;
    @(negedge clk);
    grant_i = 0;
    for (int w = 0; w < 2; w++) begin
      #1;
      check(hold_o == 1'b1, "R2 hold", int'(hold_o), 1);
      check(in_ready_o == '0 && out_valid_o == '0, "R2 no move before route",
            int'(in_ready_o | out_valid_o), 0);
      @(negedge clk);
    end
    route_vld_i = 1; route_err_i = drop;
    @(negedge clk);
    route_vld_i = 0; route_err_i = 0;
    while (!done) begin
      if (cyc > 0) @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
        if (hs_in[l])  in_cnt[l]++;
        if (hs_out[l]) out_cnt[l]++;
      end
      // stray report while already forwarding
      route_vld_i = (cyc == 2 && !drop);
      route_err_i = (cyc == 2 && !drop);
      for (int l = 0; l < LANES; l++) begin
        bit stall = ($urandom % 100) < pct;
        if (in_cnt[l] >= len[l]) begin
          in_valid_i[l] = 1'b1;
          in_data_i[l*LANE_W +: LANE_W] = LANE_W'($urandom);
          in_eof_i[l] = 1'b0;
        end else begin
          in_valid_i[l] = !stall;
          in_data_i[l*LANE_W +: LANE_W] = item(f, l, in_cnt[l]);
          in_eof_i[l] = (in_cnt[l] == len[l] - 1);
        end
        out_ready_i[l] = ($urandom % 100) >= pct;
      end
      #1;
      done = 1;
      for (int l = 0; l < LANES; l++) if (in_cnt[l] < len[l]) done = 0;
      check(release_o == done, "R6 release when all finished", int'(release_o), int'(done));
      check(err_o == drop, "R8 mode unaffected by stray report", int'(err_o), int'(drop));
      if (!done) begin
        for (int l = 0; l < LANES; l++) begin
          if (in_cnt[l] >= len[l]) begin
            check(lane_fin_o[l] && !in_ready_o[l] && !out_valid_o[l], "R5 finished lane closed",
                  int'({lane_fin_o[l], in_ready_o[l], out_valid_o[l]}), 4);
          end else if (drop) begin
            check(!out_valid_o[l], "R7 dropped frame silent", int'(out_valid_o[l]), 0);
            check(in_ready_o[l], "R7 dropped frame drained", int'(in_ready_o[l]), 1);
          end else begin
            check(in_ready_o[l] == out_ready_i[l], "R4 lane ready independent",
                  int'(in_ready_o[l]), int'(out_ready_i[l]));
            check(out_valid_o[l] == in_valid_i[l], "R3 valid passes", int'(out_valid_o[l]),
                  int'(in_valid_i[l]));
            if (out_valid_o[l]) begin
              check(out_data_o[l*LANE_W +: LANE_W] == item(f, l, out_cnt[l]), "R9 lane order",
                    int'(out_data_o[l*LANE_W +: LANE_W]), int'(item(f, l, out_cnt[l])));
              check(out_eof_o[l] == (out_cnt[l] == len[l] - 1), "R9 eof position",
                    int'(out_eof_o[l]), int'(out_cnt[l] == len[l] - 1));
            end
          end
        end
      end
      for (int l = 0; l < LANES; l++) begin
        hs_in[l]  = in_valid_i[l] && in_ready_o[l];
        hs_out[l] = out_valid_o[l] && out_ready_i[l];
      end
      cyc++;
      if (cyc > 3000) begin
        check(1'b0, "R6 frame watchdog", cyc, 0);
        done = 1;
      end
    end
    @(negedge clk);
    route_vld_i = 0; route_err_i = 0;
    in_valid_i = '0; in_eof_i = '0;
    #1;
    check(hold_o == 1'b0, "R6 hold dropped after release", int'(hold_o), 0);
    check(lane_fin_o == '0, "R6 finish flags cleared", int'(lane_fin_o), 0);
  endtask

  initial begin
    in_valid_i = '1; out_ready_i = '1; in_eof_i = '1;
    #23;
    check(hold_o == 0 && release_o == 0 && err_o == 0, "R1 control in reset",
          int'({hold_o, release_o, err_o}), 0);
    check(in_ready_o == '0 && out_valid_o == '0 && lane_fin_o == '0, "R1 lanes in reset",
          int'(in_ready_o | out_valid_o | lane_fin_o), 0);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    #1;
    check(hold_o == 0 && in_ready_o == '0, "R1 idle after reset", int'(hold_o), 0);
    in_valid_i = '0; in_eof_i = '0;
    for (int f = 0; f < NF; f++) run_frame(f);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule